// File: doc/BRIEF.md
# Wormhole Mesh Router Node

This block is one switching node of a two-dimensional mesh. It has five input ports and five output ports: one facing the attached endpoint (home), and one for each of the four mesh directions. Every input owns a small flit queue. The flit at the head of a queue that opens a packet is steered by dimension-ordered routing: first along X, then along Y, and to the home port when both coordinates match the node's own. A free output picks one requesting input in round-robin order. It stays bound to that input until the packet's closing flit has left. Body flits stream through as soon as they arrive, without waiting for the rest of the packet.

Each output has a registered crossbar stage and obeys a full flag from the neighbour it feeds. While the flag is raised nothing is written on that output. Flits then back up into the input queues, and the queues' own full flags are exported to the upstream senders. No flit is ever discarded.

Each output port has a two-state controller. FREE waits for a request. FREE→FREE fires when a single-flit packet is forwarded. FREE→HELD fires when an opening flit of a longer packet is forwarded and the winner is recorded as owner. HELD forwards the owner's flits. HELD→FREE fires when the owner's closing flit is forwarded.

Top module: `wh_router`

## Requirements
- R1: After reset every `out_valid` bit and every `in_full` bit is 0, and every output controller is FREE with its round-robin pointer at input 0.
- R2: A flit is `{kind[1:0], dst_x[CW-1:0], dst_y[CW-1:0], payload[PLD-1:0]}` from MSB down. kind 01 opens a packet, 00 is a middle flit, 10 closes a packet, and 11 is a one-flit packet. A forwarded flit leaves bit-for-bit unchanged.
- R3: Port numbers are 0 home, 1 X-increasing, 2 X-decreasing, 3 Y-increasing, 4 Y-decreasing. An opening flit goes to port 1 if dst_x > MY_X, to port 2 if dst_x < MY_X, and otherwise to port 3 or 4 if dst_y is greater or less than MY_Y. When both coordinates match it goes to port 0. Later flits follow their opening flit.
- R4: Between an opening flit (kind 01) and its closing flit on one output, only flits from the same input appear, and no other packet starts on that output.
- R5: A FREE output grants the first requesting input at or after its pointer, scanning upward and wrapping. It then moves the pointer to the winner plus one, modulo 5.
- R6: `out_valid[o]` is 1 in a cycle only if `out_full[o]` was 0 at the clock edge that loaded it.
- R7: `in_full[i]` is 1 exactly when input queue i holds DEPTH flits. Every accepted flit is delivered exactly once, and flits from one input to one output keep their order.
- R8: With the router idle and no output full, a flit written at clock edge k appears on its output at edge k+1.
- R9: Middle flits of a packet are forwarded while its closing flit has not yet been written into the router.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Write strobe per input port |
| in_flit | input | 5*FW | Input flits, port i in bits [i*FW +: FW] |
| in_full | output | 5 | Input queue full per port; the sender must hold off |
| out_valid | output | 5 | Flit present on output port this cycle |
| out_flit | output | 5*FW | Output flits, port o in bits [o*FW +: FW] |
| out_full | input | 5 | Downstream neighbour cannot take a write on this port |

## Verification
The bench builds the node with its defaults: node at (1,1), 2-bit coordinates, 8-bit payload and 4-entry queues. This is a centre position of a 4×4 grid, so random destinations reach all five routing outcomes, including both signs of each coordinate difference. The short queues make them fill quickly when outputs are blocked at random, so input-side backpressure and long stall chains appear often. Directed cases pin down the round-robin order, the exact queue-full point, the one-edge latency and forwarding before a packet's closing flit.

// File: rtl/wh_pkg.sv
package wh_pkg;
    typedef enum logic [1:0] {
        K_BODY = 2'b00,
        K_HEAD = 2'b01,
        K_TAIL = 2'b10,
        K_SOLO = 2'b11
    } kind_e;

    localparam int NPORT  = 5;
    localparam int P_HOME = 0;
    localparam int P_XPOS = 1;
    localparam int P_XNEG = 2;
    localparam int P_YPOS = 3;
    localparam int P_YNEG = 4;
endpackage

// File: rtl/wh_fifo.sv
module wh_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [NW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (cnt == NW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + NW'(do_push) - NW'(do_pop);
        end
    end
endmodule

// File: rtl/wh_route.sv
module wh_route #(
    parameter int CW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic [CW-1:0]            dx,
    input  logic [CW-1:0]            dy,
    output logic [wh_pkg::NPORT-1:0] dir
);
    import wh_pkg::*;

    always_comb begin
        dir = '0;
        if (dx > CW'(MY_X))      dir[P_XPOS] = 1'b1;
        else if (dx < CW'(MY_X)) dir[P_XNEG] = 1'b1;
        else if (dy > CW'(MY_Y)) dir[P_YPOS] = 1'b1;
        else if (dy < CW'(MY_Y)) dir[P_YNEG] = 1'b1;
        else                     dir[P_HOME] = 1'b1;
    end
endmodule

// File: rtl/wh_outsel.sv
module wh_outsel #(
    parameter int NP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic [NP-1:0] avail,
    input  logic [NP-1:0] tail_at,
    input  logic [NP-1:0] solo_at,
    input  logic          blocked,
    output logic [NP-1:0] grant,
    output logic          fire
);
    localparam int PW = $clog2(NP);

    typedef enum logic {OS_FREE, OS_HELD} ostate_e;

    ostate_e       state, nstate;
    logic [PW-1:0] ptr, owner, win;
    logic          found, take;

    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NP;
            if (!found && req[idx]) begin
                win   = PW'(idx);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OS_FREE;
            ptr   <= '0;
            owner <= '0;
        end else begin
            state <= nstate;
            if (take) begin
                owner <= win;
                ptr   <= (win == PW'(NP - 1)) ? '0 : win + 1'b1;
            end
        end
    end

    always_comb begin
        nstate = state;
        grant  = '0;
        fire   = 1'b0;
        take   = 1'b0;
        unique case (state)
            OS_FREE: begin
                if (found && !blocked) begin
                    fire       = 1'b1;
                    take       = 1'b1;
                    grant[win] = 1'b1;
                    nstate     = solo_at[win] ? OS_FREE : OS_HELD;
                end
            end
            OS_HELD: begin
                if (avail[owner] && !blocked) begin
                    fire         = 1'b1;
                    grant[owner] = 1'b1;
                    if (tail_at[owner]) nstate = OS_FREE;
                end
            end
        endcase
    end
endmodule

// File: rtl/wh_router.sv
module wh_router #(
    parameter int CW    = 2,
    parameter int PLD   = 8,
    parameter int DEPTH = 4,
    parameter int MY_X  = 1,
    parameter int MY_Y  = 1,
    localparam int FW   = 2 + 2 * CW + PLD,
    localparam int NP   = wh_pkg::NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    in_valid,
    input  logic [NP*FW-1:0] in_flit,
    output logic [NP-1:0]    in_full,
    output logic [NP-1:0]    out_valid,
    output logic [NP*FW-1:0] out_flit,
    input  logic [NP-1:0]    out_full
);
    import wh_pkg::*;

    logic [FW-1:0] head_q [NP];
    logic [NP-1:0] q_empty, q_pop, is_open, is_close, is_solo;
    logic [NP-1:0] route_v [NP];
    logic [NP-1:0] req_o   [NP];
    logic [NP-1:0] grant_o [NP];
    logic [NP-1:0] fire_o;
    logic [FW-1:0] xbar_o  [NP];

    for (genvar i = 0; i < NP; i++) begin : g_in
        logic [1:0] kind;

        wh_fifo #(.W(FW), .DEPTH(DEPTH)) q_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i]),
            .pop   (q_pop[i]),
            .wdata (in_flit[i*FW +: FW]),
            .rdata (head_q[i]),
            .empty (q_empty[i]),
            .full  (in_full[i])
        );

        assign kind        = head_q[i][FW-1 -: 2];
        assign is_open[i]  = kind[0];
        assign is_close[i] = (kind == K_TAIL);
        assign is_solo[i]  = (kind == K_SOLO);

        wh_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) rt_i (
            .dx  (head_q[i][FW-3 -: CW]),
            .dy  (head_q[i][FW-3-CW -: CW]),
            .dir (route_v[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_o[o][i] = !q_empty[i] && is_open[i] && route_v[i][o];
            end
        end
    end

    always_comb begin
        q_pop = '0;
        for (int o = 0; o < NP; o++) begin
            q_pop = q_pop | (grant_o[o] & {NP{fire_o[o]}});
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        wh_outsel #(.NP(NP)) sel_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_o[o]),
            .avail   (~q_empty),
            .tail_at (is_close),
            .solo_at (is_solo),
            .blocked (out_full[o]),
            .grant   (grant_o[o]),
            .fire    (fire_o[o])
        );

        always_comb begin
            xbar_o[o] = '0;
            for (int i = 0; i < NP; i++) begin
                if (grant_o[o][i]) xbar_o[o] = xbar_o[o] | head_q[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid[o] <= 1'b0;
            end else begin
                out_valid[o] <= fire_o[o];
            end
        end

        always_ff @(posedge clk) begin
            if (fire_o[o]) out_flit[o*FW +: FW] <= xbar_o[o];
        end
    end
endmodule

// File: rtl/wh_router_chk.sv
module wh_router_chk #(
    parameter int CW   = 2,
    parameter int PLD  = 8,
    parameter int MY_X = 1,
    parameter int MY_Y = 1,
    localparam int FW  = 2 + 2 * CW + PLD,
    localparam int NP  = wh_pkg::NPORT
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    out_valid,
    input logic [NP*FW-1:0] out_flit,
    input logic [NP-1:0]    out_full
);
    function automatic int xy_port(input logic [CW-1:0] dx, input logic [CW-1:0] dy);
        if (dx > CW'(MY_X)) return 1;
        if (dx < CW'(MY_X)) return 2;
        if (dy > CW'(MY_Y)) return 3;
        if (dy < CW'(MY_Y)) return 4;
        return 0;
    endfunction

    logic [NP-1:0] open_pkt;

    for (genvar o = 0; o < NP; o++) begin : g_chk
        logic [FW-1:0] f;
        logic [1:0]    k;
        assign f = out_flit[o*FW +: FW];
        assign k = f[FW-1 -: 2];

        always_ff @(posedge clk) begin
            if (!rst_n) open_pkt[o] <= 1'b0;
            else if (out_valid[o]) begin
                if (k == 2'b01)      open_pkt[o] <= 1'b1;
                else if (k[1])       open_pkt[o] <= 1'b0;
            end
        end

        a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> !$past(out_full[o]));

        a_r4_no_nested_start: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && k[0]) |-> !open_pkt[o]);

        a_r4_middle_inside_packet: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !k[0]) |-> open_pkt[o]);

        a_r3_route_matches_port: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && k[0]) |-> (xy_port(f[FW-3 -: CW], f[FW-3-CW -: CW]) == o));
    end
endmodule

bind wh_router wh_router_chk #(.CW(CW), .PLD(PLD), .MY_X(MY_X), .MY_Y(MY_Y)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_flit  (out_flit),
    .out_full  (out_full)
);

// File: tb/wh_router_tb.sv
`timescale 1ns/1ps
module wh_router_tb_top;
    localparam int PERIOD = 10;
    localparam int CW = 2, PLD = 8, DEPTH = 4, MY_X = 1, MY_Y = 1;
    localparam int FW = 2 + 2 * CW + PLD;
    localparam int NP = 5;
    localparam int NPKT = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    in_valid, in_full, out_valid, out_full;
    logic [NP*FW-1:0] in_flit, out_flit;

    logic          in_v [NP];
    logic [FW-1:0] in_f [NP];
    logic          rnd_full = 1'b0;
    logic          in_reset = 1'b1;

    int checks = 0, errors = 0;
    int rx_cnt [NP];
    int log0 [$];
    logic [FW-1:0] expq [NP][NP][$];
    logic [NP-1:0] open_b;
    int own_b [NP];
    int seq_n [NP];

    always #(PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_valid[i]          = in_v[i];
            in_flit[i*FW +: FW]  = in_f[i];
        end
    end

    wh_router #(.CW(CW), .PLD(PLD), .DEPTH(DEPTH), .MY_X(MY_X), .MY_Y(MY_Y)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_full(in_full), .out_valid(out_valid), .out_flit(out_flit), .out_full(out_full)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int xy_dir(input int dx, input int dy);
        if (dx > MY_X) return 1;
        if (dx < MY_X) return 2;
        if (dy > MY_Y) return 3;
        if (dy < MY_Y) return 4;
        return 0;
    endfunction

    function automatic logic [FW-1:0] mk(input logic [1:0] k, input int dx, input int dy,
                                         input int src, input int seq);
        return {k, CW'(dx), CW'(dy), 3'(src), 5'(seq)};
    endfunction

    // drive at negedge once the queue has room; release after the write edge
    task automatic send_flit(input int i, input logic [FW-1:0] f, input int o);
        @(negedge clk);
        while (in_full[i]) @(negedge clk);
        in_v[i] = 1'b1;
        in_f[i] = f;
        expq[i][o].push_back(f);
        @(posedge clk);
        #1;
        in_v[i] = 1'b0;
    endtask

    task automatic send_pkt(input int i, input int dx, input int dy, input int nbody, input bit solo);
        int o;
        o = xy_dir(dx, dy);
        if (solo) begin
            send_flit(i, mk(2'b11, dx, dy, i, seq_n[i]++), o);
        end else begin
            send_flit(i, mk(2'b01, dx, dy, i, seq_n[i]++), o);
            for (int b = 0; b < nbody; b++) send_flit(i, mk(2'b00, dx, dy, i, seq_n[i]++), o);
            send_flit(i, mk(2'b10, dx, dy, i, seq_n[i]++), o);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_reset = 1'b1;
        repeat (2) @(negedge clk);
        for (int o = 0; o < NP; o++) rx_cnt[o] = 0;
        log0.delete();
        open_b = '0;
        rst_n = 1'b1;
        in_reset = 1'b0;
    endtask

    function automatic int pending();
        int n = 0;
        for (int a = 0; a < NP; a++)
            for (int b = 0; b < NP; b++) n += expq[a][b].size();
        return n;
    endfunction

    // monitor: sampled 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (!in_reset) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o]) begin
                    logic [FW-1:0] f;
                    logic [1:0] k;
                    int src;
                    f = out_flit[o*FW +: FW];
                    k = f[FW-1 -: 2];
                    src = int'(f[7:5]);
                    rx_cnt[o]++;
                    if (o == 0) log0.push_back(src);
                    chk(out_full[o] == 1'b0, "R6 write while full", out_full[o], 0);
                    if (src >= NP || expq[src][o].size() == 0) begin
                        chk(1'b0, "R3 flit on unexpected port", f, o);
                    end else begin
                        logic [FW-1:0] e;
                        e = expq[src][o].pop_front();
                        chk(f == e, "R7 order/content", f, e);
                    end
                    if (k[0]) begin
                        chk(!open_b[o], "R4 packet started inside another", o, 0);
                        open_b[o] = (k == 2'b01);
                        own_b[o] = src;
                    end else begin
                        chk(open_b[o] && own_b[o] == src, "R4 interleaved flit", src, own_b[o]);
                        if (k == 2'b10) open_b[o] = 1'b0;
                    end
                end
            end
        end
    end

    always begin
        @(negedge clk);
        if (rnd_full) for (int o = 0; o < NP; o++) out_full[o] = (($urandom % 10) < 3);
    end

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NP; i++) begin
            in_v[i] = 1'b0;
            in_f[i] = '0;
            seq_n[i] = 0;
        end
        out_full = '0;
        open_b = '0;
        do_reset();

        // R1 reset state
        @(posedge clk); #2;
        chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
        chk(in_full == '0, "R1 in_full after reset", in_full, 0);

        // R8 and R2: one-edge latency, flit unchanged
        begin
            logic [FW-1:0] f;
            f = mk(2'b11, 1, 1, 2, 7);
            send_flit(2, f, 0);
            #1;
            chk(out_valid[0] == 1'b0, "R8 too early", out_valid[0], 0);
            @(posedge clk); #2;
            chk(out_valid[0] == 1'b1, "R8 latency", out_valid[0], 1);
            chk(out_flit[0 +: FW] == f, "R2 flit unchanged", out_flit[0 +: FW], f);
        end
        repeat (10) @(negedge clk);

        // R5 round robin and R6 hold while full
        do_reset();
        out_full = '1;
        send_pkt(1, 1, 1, 0, 1);
        send_pkt(1, 1, 1, 0, 1);
        send_pkt(2, 1, 1, 0, 1);
        send_pkt(2, 1, 1, 0, 1);
        repeat (3) @(negedge clk);
        chk(rx_cnt[0] == 0, "R6 nothing out while full", rx_cnt[0], 0);
        out_full = '0;
        repeat (10) @(negedge clk);
        chk(log0.size() == 4, "R5 grant count", log0.size(), 4);
        if (log0.size() == 4) begin
            chk(log0[0] == 1, "R5 first grant", log0[0], 1);
            chk(log0[1] == 2, "R5 second grant", log0[1], 2);
            chk(log0[2] == 1, "R5 third grant", log0[2], 1);
            chk(log0[3] == 2, "R5 fourth grant", log0[3], 2);
        end

        // R7 queue-full point
        do_reset();
        out_full = '1;
        send_flit(3, mk(2'b01, 3, 1, 3, seq_n[3]++), 1);
        for (int b = 0; b < DEPTH - 2; b++) send_flit(3, mk(2'b00, 3, 1, 3, seq_n[3]++), 1);
        #1;
        chk(in_full[3] == 1'b0, "R7 full too early", in_full[3], 0);
        send_flit(3, mk(2'b00, 3, 1, 3, seq_n[3]++), 1);
        #1;
        chk(in_full[3] == 1'b1, "R7 full at DEPTH", in_full[3], 1);
        chk(rx_cnt[1] == 0, "R6 blocked output silent", rx_cnt[1], 0);
        out_full = '0;
        send_flit(3, mk(2'b10, 3, 1, 3, seq_n[3]++), 1);
        repeat (10) @(negedge clk);
        chk(rx_cnt[1] == DEPTH + 1, "R7 all delivered", rx_cnt[1], DEPTH + 1);

        // R9 cut-through and R4 lock against a competitor
        do_reset();
        send_flit(0, mk(2'b01, 3, 1, 0, seq_n[0]++), 1);
        send_flit(0, mk(2'b00, 3, 1, 0, seq_n[0]++), 1);
        send_flit(0, mk(2'b00, 3, 1, 0, seq_n[0]++), 1);
        send_flit(4, mk(2'b11, 2, 0, 4, seq_n[4]++), 1);
        repeat (6) @(negedge clk);
        chk(rx_cnt[1] == 3, "R9 middle flits before close", rx_cnt[1], 3);
        chk(rx_cnt[1] == 3, "R4 competitor held off", rx_cnt[1], 3);
        send_flit(0, mk(2'b10, 3, 1, 0, seq_n[0]++), 1);
        repeat (6) @(negedge clk);
        chk(rx_cnt[1] == 5, "R4 competitor after close", rx_cnt[1], 5);
        chk(pending() == 0, "R7 directed drained", pending(), 0);

        // random traffic with random downstream backpressure
        do_reset();
        rnd_full = 1'b1;
        for (int i = 0; i < NP; i++) begin
            fork
                automatic int p = i;
                begin
                    for (int n = 0; n < NPKT; n++) begin
                        int dx, dy, nb;
                        dx = $urandom % 4;
                        dy = $urandom % 4;
                        nb = $urandom % 3;
                        send_pkt(p, dx, dy, nb, (nb == 0) && ($urandom % 2 == 1));
                        repeat ($urandom % 3) @(negedge clk);
                    end
                end
            join_none
        end
        wait fork;
        rnd_full = 1'b0;
        @(negedge clk);
        out_full = '0;
        repeat (300) @(negedge clk);
        chk(pending() == 0, "R7 random traffic drained", pending(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule